// File: doc/BRIEF.md
# Configuration EEPROM command controller

This block stands in for a small byte-wide configuration EEPROM that software drives through two registers: a command word and an 8-bit data byte. A command word selects one of eight operations and a byte address. Reads copy a stored byte into the data byte. Programming operations follow real EEPROM rules: a program can only clear bits, and an erase returns bytes to all ones. A write-enable latch must be armed before any change to the array is allowed.

The reload operation copies a 48-bit station address out of the array into a register that drives the `macAddr` output. It does this only when the first byte holds a fixed signature; otherwise it raises a failure flag. Every accepted command keeps the block busy for a set number of cycles, and any command that arrives in that window is dropped. A reset restores the factory image of the array, disarms the latch and presents the factory station address, which is the result a reload of that image gives.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: After reset, `busy` is low, `cmdStatus` is zero, `dataOut` is 0x00 and `macAddr` equals `DEFAULT_MAC`. The array holds the factory image: byte 0 = 0xA5, bytes 1..6 = `DEFAULT_MAC` taken from bits 47:40 down to 7:0, and 0xFF in every other byte.
- R2: On `cmdIn`, bits 30:28 carry the operation code and bits 6:0 the byte address. The codes are 0 read, 1 latch disarm, 2 latch arm, 3 program, 4 program-all, 5 erase, 6 erase-all, 7 reload. `cmdStatus` reads back busy in bit 31, the last accepted code in 30:28, the reload failure flag in bit 9 and the last accepted address in 6:0.
- R3: A read copies the addressed byte to `dataOut`. A `dataWr` pulse loads `dataIn` into `dataOut`. When both occur in the same cycle, the read wins.
- R4: A program (code 3) with the latch armed replaces the addressed byte with its bitwise AND with the data byte.
- R5: A program-all (code 4) with the latch armed ANDs the data byte into every byte of the array.
- R6: An erase (code 5) with the latch armed sets the addressed byte to 0xFF. An erase-all (code 6) with the latch armed sets all bytes to 0xFF.
- R7: Code 2 arms the latch and code 1 disarms it. Reset also disarms it. While the latch is disarmed, codes 3, 4, 5 and 6 leave the array unchanged.
- R8: A reload (code 7) when byte 0 equals 0xA5 loads `macAddr` with byte 1 in bits 47:40, through byte 6 in bits 7:0, and clears status bit 9. No other operation changes `macAddr`.
- R9: A reload when byte 0 is not 0xA5 leaves `macAddr` unchanged and sets status bit 9. The next accepted command of any other code clears that bit.
- R10: An accepted command holds `busy` high for exactly `BUSY_CYCLES` cycles, starting in the cycle after the command is accepted. A command that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWr | input | 1 | Command word write strobe |
| cmdIn | input | 32 | Command word (code 30:28, address 6:0) |
| dataWr | input | 1 | Data byte write strobe |
| dataIn | input | 8 | Data byte to load |
| dataOut | output | 8 | Data byte readback |
| cmdStatus | output | 32 | Command/status readback |
| busy | output | 1 | Command in progress |
| macAddr | output | 48 | Station address register |

## Verification
The bench targets the rules that separate an EEPROM from plain RAM. It repeats programs on one byte, so a design that overwrites instead of ANDing gives the wrong result. It also sends programs and erases with the latch disarmed, where a design that ignores the latch would change bytes. A failed reload must keep the old station address and raise the flag, and the next command must drop that flag; a design that loads unconditionally or leaves the flag stuck shows up here. The bench also sends a command one cycle after another, which catches a design that executes commands it should drop while busy. A final reset is followed by a program attempt, to show that reset disarms the latch.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_DISARM = 3'd1,
    OP_ARM    = 3'd2,
    OP_PROG   = 3'd3,
    OP_PROGALL = 3'd4,
    OP_ERASE  = 3'd5,
    OP_ERASEALL = 3'd6,
    OP_RELOAD = 3'd7
  } eeOp_e;

  // Strobes from the sequencer to the storage datapath (already latch-gated)
  typedef struct packed {
    logic rd;
    logic prog;
    logic progAll;
    logic erase;
    logic eraseAll;
    logic reload;
  } eeStrobe_t;

endpackage

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_cmd_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int BUSY_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [31:0]       cmdIn,
  input  logic              sigOk,
  output eeStrobe_t         strobe,
  output logic [ADDR_W-1:0] opAddr,
  output logic              busy,
  output logic [31:0]       cmdStatus
);
  localparam int CNT_W  = $clog2(BUSY_CYCLES + 1);
  localparam int PAD_HI = 28 - 10;
  localparam int PAD_LO = 9 - ADDR_W;

  logic [CNT_W-1:0]  busyCnt;
  logic              armed;
  logic              failFlag;
  eeOp_e             lastOp;
  logic [ADDR_W-1:0] lastAddr;
  logic              accept;
  eeOp_e             opCode;
  logic              unusedCmdBits;

  assign opCode        = eeOp_e'(cmdIn[30:28]);
  assign opAddr        = cmdIn[ADDR_W-1:0];
  assign unusedCmdBits = ^{cmdIn[31], cmdIn[27:ADDR_W]};
  assign busy          = (busyCnt != '0);
  assign accept        = cmdWr && !busy;

  always_comb begin
    strobe = '0;
    if (accept) begin
      case (opCode)
        OP_READ:     strobe.rd       = 1'b1;
        OP_PROG:     strobe.prog     = armed;
        OP_PROGALL:  strobe.progAll  = armed;
        OP_ERASE:    strobe.erase    = armed;
        OP_ERASEALL: strobe.eraseAll = armed;
        OP_RELOAD:   strobe.reload   = 1'b1;
        default:     strobe          = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt  <= '0;
      armed    <= 1'b0;
      failFlag <= 1'b0;
      lastOp   <= OP_READ;
      lastAddr <= '0;
    end else if (accept) begin
      busyCnt  <= CNT_W'(BUSY_CYCLES);
      lastOp   <= opCode;
      lastAddr <= opAddr;
      failFlag <= (opCode == OP_RELOAD) && !sigOk;
      if (opCode == OP_ARM)         armed <= 1'b1;
      else if (opCode == OP_DISARM) armed <= 1'b0;
    end else if (busy) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  assign cmdStatus = {busy, lastOp, {PAD_HI{1'b0}}, failFlag,
                      {PAD_LO{1'b0}}, lastAddr};

endmodule

// File: rtl/eeprom_cmd_store.sv
module eeprom_cmd_store
  import eeprom_cmd_pkg::*;
#(
  parameter int          DEPTH       = 128,
  parameter logic [7:0]  SIGNATURE   = 8'hA5,
  parameter logic [47:0] DEFAULT_MAC = 48'h02005E102030,
  localparam int         ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  eeStrobe_t         strobe,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic              dataWr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              sigOk,
  output logic [47:0]       macAddr
);
  localparam int MAC_BYTES = 6;

  logic [7:0]  memArr [DEPTH];
  logic [7:0]  dataReg;
  logic [47:0] macReg;
  logic [47:0] imageMac;

  function automatic logic [7:0] factoryByte(int idx);
    if (idx == 0)              return SIGNATURE;
    else if (idx <= MAC_BYTES) return DEFAULT_MAC[8*(MAC_BYTES-idx) +: 8];
    else                       return 8'hFF;
  endfunction

  assign sigOk = (memArr[0] == SIGNATURE);

  // Station address image, byte 1 lands in the top octet
  always_comb begin
    for (int b = 1; b <= MAC_BYTES; b++)
      imageMac[8*(MAC_BYTES-b) +: 8] = memArr[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memArr[i] <= factoryByte(i);
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.eraseAll)
          memArr[i] <= 8'hFF;
        else if (strobe.progAll)
          memArr[i] <= memArr[i] & dataReg;
        else if (opAddr == ADDR_W'(i)) begin
          if (strobe.erase)     memArr[i] <= 8'hFF;
          else if (strobe.prog) memArr[i] <= memArr[i] & dataReg;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dataReg <= 8'h00;
    else if (strobe.rd)  dataReg <= memArr[opAddr];
    else if (dataWr)     dataReg <= dataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       macReg <= DEFAULT_MAC;
    else if (strobe.reload && sigOk) macReg <= imageMac;
  end

  assign dataOut = dataReg;
  assign macAddr = macReg;

endmodule

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl
  import eeprom_cmd_pkg::*;
#(
  parameter int          DEPTH       = 128,
  parameter int          BUSY_CYCLES = 4,
  parameter logic [7:0]  SIGNATURE   = 8'hA5,
  parameter logic [47:0] DEFAULT_MAC = 48'h02005E102030
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic [31:0] cmdIn,
  input  logic        dataWr,
  input  logic [7:0]  dataIn,
  output logic [7:0]  dataOut,
  output logic [31:0] cmdStatus,
  output logic        busy,
  output logic [47:0] macAddr
);
  localparam int ADDR_W = $clog2(DEPTH);

  eeStrobe_t         strobe;
  logic [ADDR_W-1:0] opAddr;
  logic              sigOk;

  eeprom_cmd_seq #(
    .ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_seq (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdIn(cmdIn), .sigOk(sigOk),
    .strobe(strobe), .opAddr(opAddr), .busy(busy), .cmdStatus(cmdStatus)
  );

  eeprom_cmd_store #(
    .DEPTH(DEPTH), .SIGNATURE(SIGNATURE), .DEFAULT_MAC(DEFAULT_MAC)
  ) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opAddr(opAddr),
    .dataWr(dataWr), .dataIn(dataIn), .dataOut(dataOut),
    .sigOk(sigOk), .macAddr(macAddr)
  );

endmodule

// File: rtl/eeprom_cmd_checker.sv
module eeprom_cmd_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cmdWr,
  input logic [2:0]  cmdOp,
  input logic        dataWr,
  input logic [7:0]  dataOut,
  input logic [31:0] cmdStatus,
  input logic        busy,
  input logic [47:0] macAddr
);
  logic accepted;
  assign accepted = cmdWr && !busy;

  // R10: an accepted command raises busy on the next cycle
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> busy);

  // R10: a command arriving while busy changes neither data nor address
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWr && !dataWr) |=> ($stable(dataOut) && $stable(macAddr)));

  // R9: any accepted non-reload command leaves the failure flag clear
  assert_fail_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && cmdOp != 3'd7) |=> !cmdStatus[9]);

  // R8: the station address moves only after an accepted reload
  assert_mac_only_reload_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(macAddr) |-> $past(accepted && cmdOp == 3'd7));

  // R3: the data byte moves only after a read or a data write
  assert_data_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataOut) |-> $past((accepted && cmdOp == 3'd0) || dataWr));

  // R2: busy bit of the status word tracks the busy output
  assert_status_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdStatus[31] == busy);
endmodule

bind eeprom_cmd_ctrl eeprom_cmd_checker u_checker (
  .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdOp(cmdIn[30:28]),
  .dataWr(dataWr), .dataOut(dataOut), .cmdStatus(cmdStatus),
  .busy(busy), .macAddr(macAddr)
);

// File: tb/tb_eeprom_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_eeprom_cmd_ctrl;
  localparam int          BUSY_CYCLES = 4;
  localparam logic [47:0] DEF_MAC     = 48'h02005E102030;
  localparam int          NVEC        = 12;

  // {code, address, data byte, expected byte read back at address}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0, 8'h00, 8'h00, 8'hA5},
    {8'd3, 8'h0A, 8'h0F, 8'hFF},
    {8'd2, 8'h0A, 8'h00, 8'hFF},
    {8'd3, 8'h0A, 8'h3C, 8'h3C},
    {8'd3, 8'h0A, 8'hF0, 8'h30},
    {8'd5, 8'h0A, 8'h00, 8'hFF},
    {8'd3, 8'h14, 8'h5A, 8'h5A},
    {8'd4, 8'h14, 8'hF7, 8'h52},
    {8'd1, 8'h14, 8'h00, 8'h52},
    {8'd5, 8'h14, 8'h00, 8'h52},
    {8'd2, 8'h14, 8'h00, 8'h52},
    {8'd6, 8'h14, 8'h00, 8'hFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWr = 1'b0;
  logic [31:0] cmdIn = '0;
  logic        dataWr = 1'b0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic [31:0] cmdStatus;
  logic        busy;
  logic [47:0] macAddr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  eeprom_cmd_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .DEFAULT_MAC(DEF_MAC)) dut (
    .clk(clk), .rstN(rstN), .cmdWr(cmdWr), .cmdIn(cmdIn), .dataWr(dataWr),
    .dataIn(dataIn), .dataOut(dataOut), .cmdStatus(cmdStatus),
    .busy(busy), .macAddr(macAddr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [7:0] op);
    case (op)
      8'd0:    return "R3";
      8'd3:    return "R4";
      8'd4:    return "R5";
      8'd5, 8'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [2:0] op, input logic [6:0] addr);
    @(negedge clk);
    waitIdle();
    cmdIn = {1'b0, op, 21'd0, addr};
    cmdWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0;
    waitIdle();
  endtask

  task automatic loadData(input logic [7:0] d);
    @(negedge clk);
    dataIn = d;
    dataWr = 1'b1;
    @(negedge clk);
    dataWr = 1'b0;
  endtask

  task automatic readByte(input logic [6:0] addr, output logic [7:0] val);
    sendCmd(3'd0, addr);
    val = dataOut;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb;
    int busyLen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 status", 64'(cmdStatus), 64'd0);
    check("R1 data", 64'(dataOut), 64'd0);
    check("R1 mac", 64'(macAddr), 64'(DEF_MAC));
    rstN = 1'b1;
    readByte(7'd1, rb);
    check("R1 image byte1", 64'(rb), 64'h02);
    readByte(7'd6, rb);
    check("R1 image byte6", 64'(rb), 64'h30);
    readByte(7'd90, rb);
    check("R1 image blank", 64'(rb), 64'hFF);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] op, ad, wd, ex;
      {op, ad, wd, ex} = VEC[v];
      loadData(wd);
      sendCmd(op[2:0], ad[6:0]);
      readByte(ad[6:0], rb);
      check($sformatf("%s vector %0d", reqOf(op), v), 64'(rb), 64'(ex));
    end
    readByte(7'd0, rb);
    check("R6 erase-all byte0", 64'(rb), 64'hFF);

    // R2 status fields after an accepted command
    loadData(8'hFF);
    sendCmd(3'd3, 7'h2B);
    check("R2 status fields", 64'(cmdStatus), 64'h3000_002B);

    // R3 read wins over a simultaneous data write
    @(negedge clk);
    cmdIn = {1'b0, 3'd0, 21'd0, 7'h05};
    cmdWr = 1'b1; dataIn = 8'h12; dataWr = 1'b1;
    @(negedge clk);
    cmdWr = 1'b0; dataWr = 1'b0;
    check("R3 read priority", 64'(dataOut), 64'hFF);
    waitIdle();

    // R9 failed reload: signature missing
    sendCmd(3'd7, 7'd0);
    check("R9 fail flag set", 64'(cmdStatus[9]), 64'd1);
    check("R9 mac kept", 64'(macAddr), 64'(DEF_MAC));
    sendCmd(3'd0, 7'd3);
    check("R9 fail flag cleared", 64'(cmdStatus[9]), 64'd0);

    // R8 program signature and address bytes, then reload
    loadData(8'hA5); sendCmd(3'd3, 7'd0);
    for (int b = 1; b <= 6; b++) begin
      loadData(8'(8'h11 * b));
      sendCmd(3'd3, 7'(b));
    end
    sendCmd(3'd7, 7'd0);
    check("R8 mac loaded", 64'(macAddr), 64'h112233445566);
    check("R8 fail clear", 64'(cmdStatus[9]), 64'd0);

    // R10 busy length and command dropped while busy
    @(negedge clk);
    cmdIn = {1'b0, 3'd5, 21'd0, 7'd1};
    cmdWr = 1'b1;
    @(negedge clk);
    cmdIn = {1'b0, 3'd5, 21'd0, 7'd2};
    busyLen = 0;
    if (busy) busyLen++;
    @(negedge clk);
    cmdWr = 1'b0;
    while (busy) begin
      busyLen++;
      @(negedge clk);
    end
    check("R10 busy cycles", 64'(busyLen), 64'(BUSY_CYCLES));
    readByte(7'd1, rb);
    check("R10 first erase done", 64'(rb), 64'hFF);
    readByte(7'd2, rb);
    check("R10 busy command ignored", 64'(rb), 64'h22);

    // R7 reset disarms the latch
    sendCmd(3'd2, 7'd0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check("R1 mac after reset", 64'(macAddr), 64'(DEF_MAC));
    loadData(8'h00);
    sendCmd(3'd3, 7'd0);
    readByte(7'd0, rb);
    check("R7 latch cleared by reset", 64'(rb), 64'hA5);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule